// File: doc/BRIEF.md
# Advance-on-Hit Replacement Pointer Tag Table

This block is a fully associative tag table of 64 slots. Any tag may live in any slot. Each slot holds a valid flag, a tag and a small payload. A lookup is purely combinational. The request tag is compared against every valid slot in parallel, and the block returns a hit flag, the number of the matching slot and that slot's payload.

Victim choice does not keep age state for each slot. A single pointer always names the slot that the next allocation will overwrite. The pointer steps forward by one, wrapping at the top, only when its own slot is used:

- by a hit on that slot, or
- by a fill, because a fill always lands in that slot.

A hit on any other slot leaves the pointer where it is. Allocation goes through the pointer even when other slots are still empty, so the choice is fully deterministic.

The controller decodes each cycle into one of six named actions, each with its own transition of the pointer:

- IDLE: no request; pointer held.
- PASS: a miss without allocation; pointer held.
- HOLD: a hit on a slot other than the pointer; pointer held.
- STEP: a hit on the pointer slot; pointer moves to the next slot.
- FILL: a miss with allocation; the slot under the pointer is written and the pointer moves to the next slot.
- FLUSH: a synchronous flush; all valid flags cleared and the pointer returned to slot 0.

FLUSH has priority over any request in the same cycle.

Top module: `rptr_tag_table`

## Requirements
- R1: After reset every slot is invalid, `victim_idx` is 0 and every lookup misses.
- R2: With `req_valid` high, `hit` is high in the same cycle exactly when a valid slot holds `req_tag`, and `hit_idx` gives that slot's number. With `req_valid` low, `hit` is low.
- R3: A hit on the slot named by `victim_idx` moves `victim_idx` to the next slot at the following clock edge.
- R4: A hit on any other slot leaves `victim_idx` unchanged.
- R5: A miss with `req_alloc` high writes `req_tag` and `req_payload` into the slot named by `victim_idx` and marks it valid, even when other slots are invalid. `victim_idx` then advances by one.
- R6: A miss with `req_alloc` low changes nothing: `victim_idx` holds and the tag still misses on later lookups.
- R7: `victim_idx` wraps from 63 to 0, both on a hit and on a fill.
- R8: A high `flush` at a clock edge clears every valid flag and sets `victim_idx` to 0, and it overrides a request in the same cycle.
- R9: On a hit, `hit_payload` equals the payload written when that slot was last filled.
- R10: A fill evicts the tag previously held in the overwritten slot, so that old tag misses afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Synchronous clear of all slots and of the pointer |
| req_valid | input | 1 | Lookup request present this cycle |
| req_tag | input | 16 | Tag to look up, and to store on a fill |
| req_alloc | input | 1 | On a miss, fill the pointer slot with this request |
| req_payload | input | 8 | Payload stored on a fill |
| hit | output | 1 | Combinational hit flag |
| hit_idx | output | 6 | Number of the matching slot; 0 when there is no hit |
| hit_payload | output | 8 | Payload of the matching slot; 0 when there is no hit |
| victim_idx | output | 6 | Current replacement pointer |

## Verification
The bench builds the table with its default parameters: 64 slots, 16-bit tags and 8-bit payloads.

With the full slot count, a directed pass can fill the table completely. It then walks the pointer through all 64 positions with hits on the pointer slot, which brings the wrap from 63 to 0 within reach on both the hit and the fill paths.

Random traffic then draws tags from a pool slightly larger than the table. This keeps a mix of pointer hits, other-slot hits, evictions and non-allocating misses, and it includes flushes that collide with requests.

// File: rtl/rptr_pkg.sv
package rptr_pkg;

    // Per-cycle action chosen by the pointer controller
    typedef enum logic [2:0] {
        ACT_IDLE  = 3'd0,   // no request
        ACT_PASS  = 3'd1,   // miss, no allocation
        ACT_HOLD  = 3'd2,   // hit on a non-pointer slot
        ACT_STEP  = 3'd3,   // hit on the pointer slot
        ACT_FILL  = 3'd4,   // miss with allocation
        ACT_FLUSH = 3'd5    // clear all slots
    } rptr_act_e;

endpackage

// File: rtl/rptr_match.sv
module rptr_match #(
    parameter int ENTRIES = 64,
    parameter int TAG_W   = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [TAG_W-1:0] req_tag,
    input  logic [ENTRIES-1:0] slot_valid,
    input  logic [TAG_W-1:0] slot_tag [ENTRIES],
    output logic             hit,
    output logic [IDX_W-1:0] hit_idx
);

    logic [ENTRIES-1:0] match_vec;

    // One comparator per slot
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match_vec[g] = req_valid && slot_valid[g] && (slot_tag[g] == req_tag);
    end

    // Lowest-index encoder; matches are unique in normal use
    always_comb begin
        hit_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match_vec[i]) hit_idx = IDX_W'(i);
        end
    end

    assign hit = |match_vec;

    // R2: a reported hit names a valid slot holding the request tag
    assert_hit_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (slot_valid[hit_idx] && slot_tag[hit_idx] == req_tag));

    // R2: no hit without a request
    assert_hit_needs_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> !hit);

    // R2: fills keep tags unique, so at most one comparator fires
    assert_unique_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match_vec));

endmodule

// File: rtl/rptr_store.sv
module rptr_store #(
    parameter int ENTRIES = 64,
    parameter int TAG_W   = 16,
    parameter int PAY_W   = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr_all,
    input  logic               fill_we,
    input  logic [IDX_W-1:0]   fill_idx,
    input  logic [TAG_W-1:0]   fill_tag,
    input  logic [PAY_W-1:0]   fill_pay,
    input  logic [IDX_W-1:0]   rd_idx,
    input  logic               rd_en,
    output logic [ENTRIES-1:0] slot_valid,
    output logic [TAG_W-1:0]   slot_tag [ENTRIES],
    output logic [PAY_W-1:0]   rd_pay
);

    logic [PAY_W-1:0] pay_q [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        logic sel;
        assign sel = fill_we && (fill_idx == IDX_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_valid[g] <= 1'b0;
            end else if (clr_all) begin
                slot_valid[g] <= 1'b0;
            end else if (sel) begin
                slot_valid[g] <= 1'b1;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_tag[g] <= '0;
                pay_q[g]    <= '0;
            end else if (sel && !clr_all) begin
                slot_tag[g] <= fill_tag;
                pay_q[g]    <= fill_pay;
            end
        end
    end

    assign rd_pay = rd_en ? pay_q[rd_idx] : '0;

    // R5: a fill leaves its slot valid and holding the written tag
    assert_fill_written_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_we && !clr_all) |=> (slot_valid[$past(fill_idx)] &&
                                   slot_tag[$past(fill_idx)] == $past(fill_tag)));

    // R8: a clear empties every slot
    assert_clear_all_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all |=> (slot_valid == '0));

endmodule

// File: rtl/rptr_ctrl.sv
module rptr_ctrl
    import rptr_pkg::*;
#(
    parameter int ENTRIES = 64,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             req_valid,
    input  logic             req_alloc,
    input  logic             hit,
    input  logic [IDX_W-1:0] hit_idx,
    output logic [IDX_W-1:0] ptr,
    output logic             fill_we,
    output logic             clr_all,
    output rptr_act_e        act
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    logic [IDX_W-1:0] ptr_q, ptr_d, ptr_inc;

    assign ptr_inc = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;

    // Action decode
    always_comb begin
        if (flush)                      act = ACT_FLUSH;
        else if (!req_valid)            act = ACT_IDLE;
        else if (hit && hit_idx == ptr_q) act = ACT_STEP;
        else if (hit)                   act = ACT_HOLD;
        else if (req_alloc)             act = ACT_FILL;
        else                            act = ACT_PASS;
    end

    // Next pointer per action
    always_comb begin
        ptr_d = ptr_q;
        unique case (act)
            ACT_IDLE:  ptr_d = ptr_q;
            ACT_PASS:  ptr_d = ptr_q;
            ACT_HOLD:  ptr_d = ptr_q;
            ACT_STEP:  ptr_d = ptr_inc;
            ACT_FILL:  ptr_d = ptr_inc;
            ACT_FLUSH: ptr_d = '0;
            default:   ptr_d = ptr_q;
        endcase
    end

    // Pointer register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    // Strobes to the store
    always_comb begin
        fill_we = 1'b0;
        clr_all = 1'b0;
        unique case (act)
            ACT_FILL:  fill_we = 1'b1;
            ACT_FLUSH: clr_all = 1'b1;
            default: ;
        endcase
    end

    assign ptr = ptr_q;

    // R3 / R7: a hit on the pointer slot moves it on by one, wrapping at the top
    assert_step_on_ptr_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && req_valid && hit && hit_idx == ptr_q) |=>
            (ptr_q == (($past(ptr_q) == LAST) ? '0 : $past(ptr_q) + 1'b1)));

    // R4: a hit elsewhere holds the pointer
    assert_hold_on_other_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && req_valid && hit && hit_idx != ptr_q) |=> $stable(ptr_q));

    // R5 / R7: a fill moves the pointer on by one
    assert_step_on_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && req_valid && !hit && req_alloc) |=>
            (ptr_q == (($past(ptr_q) == LAST) ? '0 : $past(ptr_q) + 1'b1)));

    // R6: a non-allocating miss holds the pointer
    assert_hold_on_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && req_valid && !hit && !req_alloc) |=> $stable(ptr_q));

    // R8: flush returns the pointer to zero
    assert_flush_ptr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (ptr_q == '0));

endmodule

// File: rtl/rptr_tag_table.sv
module rptr_tag_table
    import rptr_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int TAG_W   = 16,
    parameter int PAY_W   = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             req_valid,
    input  logic [TAG_W-1:0] req_tag,
    input  logic             req_alloc,
    input  logic [PAY_W-1:0] req_payload,
    output logic             hit,
    output logic [IDX_W-1:0] hit_idx,
    output logic [PAY_W-1:0] hit_payload,
    output logic [IDX_W-1:0] victim_idx
);

    logic [ENTRIES-1:0] slot_valid;
    logic [TAG_W-1:0]   slot_tag [ENTRIES];
    logic               fill_we;
    logic               clr_all;
    rptr_act_e          act;

    rptr_match #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_match (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_tag    (req_tag),
        .slot_valid (slot_valid),
        .slot_tag   (slot_tag),
        .hit        (hit),
        .hit_idx    (hit_idx)
    );

    rptr_ctrl #(.ENTRIES(ENTRIES)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .req_valid (req_valid),
        .req_alloc (req_alloc),
        .hit       (hit),
        .hit_idx   (hit_idx),
        .ptr       (victim_idx),
        .fill_we   (fill_we),
        .clr_all   (clr_all),
        .act       (act)
    );

    rptr_store #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .PAY_W(PAY_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_all    (clr_all),
        .fill_we    (fill_we),
        .fill_idx   (victim_idx),
        .fill_tag   (req_tag),
        .fill_pay   (req_payload),
        .rd_idx     (hit_idx),
        .rd_en      (hit),
        .slot_valid (slot_valid),
        .slot_tag   (slot_tag),
        .rd_pay     (hit_payload)
    );

    // R1: out of reset the pointer sits at slot zero
    assert_reset_ptr_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (victim_idx == '0));

    // R5: a fill is only issued on a miss with allocation
    assert_fill_on_miss_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fill_we |-> (req_valid && !hit && req_alloc && !flush && act == ACT_FILL));

endmodule

// File: tb/rptr_tag_table_tb_top.sv
`timescale 1ns/1ps
module rptr_tag_table_tb_top;

    localparam int N = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        req_valid = 1'b0;
    logic [15:0] req_tag = '0;
    logic        req_alloc = 1'b0;
    logic [7:0]  req_payload = '0;
    logic        hit;
    logic [5:0]  hit_idx;
    logic [7:0]  hit_payload;
    logic [5:0]  victim_idx;

    int checks = 0;
    int fails  = 0;

    // Reference model
    bit          m_valid [N];
    int          m_tag   [N];
    int          m_pay   [N];
    int          m_ptr;

    always #2.5 clk = ~clk;

    rptr_tag_table dut_i (
        .clk(clk), .rst_n(rst_n), .flush(flush), .req_valid(req_valid),
        .req_tag(req_tag), .req_alloc(req_alloc), .req_payload(req_payload),
        .hit(hit), .hit_idx(hit_idx), .hit_payload(hit_payload),
        .victim_idx(victim_idx)
    );

    task automatic check(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    function automatic int model_find(input int t);
        for (int i = 0; i < N; i++)
            if (m_valid[i] && m_tag[i] == t) return i;
        return -1;
    endfunction

    // One cycle: drive at negedge, compare combinational outputs, update model at posedge
    task automatic step(input bit f, input bit v, input int t, input bit a, input int p,
                        input string rq);
        int e;
        @(negedge clk);
        flush = f; req_valid = v; req_tag = 16'(t); req_alloc = a; req_payload = 8'(p);
        #1;
        e = v ? model_find(t) : -1;
        check(hit == (e >= 0), {rq, " R2 hit"}, int'(hit), int'(e >= 0));
        if (e >= 0) begin
            check(int'(hit_idx) == e, {rq, " R2 hit_idx"}, int'(hit_idx), e);
            check(int'(hit_payload) == m_pay[e], {rq, " R9 payload"}, int'(hit_payload), m_pay[e]);
        end
        check(int'(victim_idx) == m_ptr, {rq, " victim"}, int'(victim_idx), m_ptr);
        @(posedge clk);
        if (f) begin
            for (int i = 0; i < N; i++) m_valid[i] = 1'b0;
            m_ptr = 0;
        end else if (v) begin
            if (e >= 0) begin
                if (e == m_ptr) m_ptr = (m_ptr + 1) % N;
            end else if (a) begin
                m_valid[m_ptr] = 1'b1; m_tag[m_ptr] = t; m_pay[m_ptr] = p;
                m_ptr = (m_ptr + 1) % N;
            end
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        finish_run();
    end

    initial begin
        for (int i = 0; i < N; i++) begin m_valid[i] = 0; m_tag[i] = 0; m_pay[i] = 0; end
        m_ptr = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state
        #1 check(victim_idx == 0, "R1 victim after reset", int'(victim_idx), 0);
        step(0, 1, 16'h0000, 0, 0, "R1");
        step(0, 1, 16'h1234, 0, 0, "R1");

        // R6: miss without alloc leaves everything
        step(0, 1, 500, 0, 7, "R6");
        step(0, 1, 500, 0, 7, "R6");
        check(victim_idx == 0, "R6 pointer held", int'(victim_idx), 0);

        // R5: fill all slots in pointer order; R7 wrap after slot 63
        for (int i = 0; i < N; i++) step(0, 1, 1000 + i, 1, (i * 3) & 255, "R5");
        @(negedge clk);
        check(victim_idx == 0, "R7 fill wrap", int'(victim_idx), 0);

        // R4: hit on other slot holds pointer
        step(0, 1, 1005, 0, 0, "R4");
        @(negedge clk);
        check(victim_idx == 0, "R4 pointer held", int'(victim_idx), 0);

        // R3: walk pointer with hits on its slot, R7 hit wrap
        for (int i = 0; i < N; i++) step(0, 1, 1000 + i, 0, 0, "R3");
        @(negedge clk);
        check(victim_idx == 0, "R7 hit wrap", int'(victim_idx), 0);

        // R10: eviction of slot 0
        step(0, 1, 2000, 1, 99, "R10");
        step(0, 1, 1000, 0, 0, "R10");
        @(negedge clk); #1;
        check(!hit, "R10 evicted tag misses", int'(hit), 0);

        // R8: flush with simultaneous allocating request
        step(1, 1, 3000, 1, 5, "R8");
        @(negedge clk);
        check(victim_idx == 0, "R8 pointer zero", int'(victim_idx), 0);
        step(0, 1, 3000, 0, 0, "R8");
        step(0, 1, 1010, 0, 0, "R8");

        // R5 with invalid slots elsewhere: fill goes to pointer slot
        step(0, 1, 4000, 1, 17, "R5");
        step(0, 1, 4000, 0, 0, "R5");

        // Random traffic against the model
        for (int k = 0; k < 4000; k++) begin
            bit f = ($urandom_range(0, 199) == 0);
            bit v = ($urandom_range(0, 9) != 0);
            bit a = ($urandom_range(0, 9) < 7);
            step(f, v, int'($urandom_range(0, 79)), a, int'($urandom_range(0, 255)), "RND");
        end

        finish_run();
    end

endmodule